// File: doc/BRIEF.md
# Phase-Correct PWM Timer Channel

This block is an up/down timer channel that produces a dual-slope pulse-width waveform with one compare unit. A counter climbs from zero to its all-ones top value, turns, and descends back to zero, moving one step only on cycles where the external prescaler asserts `tick`. One full triangle therefore takes 2·(2^W − 1) ticks. At the default width of 8 bits this is 510 ticks, so the output frequency is clk / (N · 510) for a prescale factor N.

Software writes a compare value into a holding register. The channel copies it into the active compare register only when the counter arrives at top. The output pin is driven to one level when the counter matches the compare value on the way up and to the other level when it matches on the way down. The 2-bit mode input selects a non-inverting waveform, an inverting waveform, or no waveform. An overflow flag records each arrival at zero and a match flag records each compare match. Each flag is sticky and has its own clear strobe.

When the active compare value has been top and the newly loaded value is not, the pin moves to the up-match level at the turnaround, although no match takes place. This keeps the pulse centred on the bottom of the triangle.

Top module: `pcpwm_timer`

## Requirements
- R1: After synchronous reset the count is 0 and rising, both compare registers hold 0, `pwm_out` is 0 and both flags are 0.
- R2: The count changes only on cycles with `tick` high. It rises by one per tick to 2^W−1, then falls by one per tick to 0, then rises again, so it never holds its value across a tick.
- R3: `ovf_flag` is set on the edge where the count arrives at 0 and stays set until `ovf_clr` is high. An arrival at 0 in the same cycle as `ovf_clr` leaves the flag set.
- R4: `cmp_flag` is set on the edge where the count arrives at the compare value in either direction, including an arrival at top when the newly loaded value is top. It stays set until `cmp_clr` is high, and a match in the same cycle as `cmp_clr` wins. The turnaround transition of R10 does not set it.
- R5: With `mode` = 2'b10 (non-inverting), a match reached while rising drives `pwm_out` to 0, and a match reached while falling or at top drives it to 1.
- R6: With `mode` = 2'b11 (inverting), the pin levels of R5 and R10 are reversed.
- R7: With `mode` = 2'b00 or 2'b01 (disconnected), `pwm_out` keeps its last value whatever the counter does.
- R8: In non-inverting mode a compare value of 0 keeps `pwm_out` at 0 for whole periods, and a value of 2^W−1 keeps it at 1. In inverting mode the levels are the complements.
- R9: A write to the compare value takes effect only at the next arrival at top. Matches are tested against the newly loaded value from that arrival onward.
- R10: At an arrival at top where the active value was 2^W−1 and the loaded value is not, `pwm_out` is driven to the up-match level (0 when non-inverting) without a compare match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaler clock enable; the counter steps when high |
| ocr_wr | input | 1 | Write strobe for the compare holding register |
| ocr_wdata | input | W | Compare value to hold |
| mode | input | 2 | 00/01 disconnected, 10 non-inverting, 11 inverting |
| ovf_clr | input | 1 | Clears the overflow flag when high |
| cmp_clr | input | 1 | Clears the match flag when high |
| cnt_o | output | W | Current count |
| pwm_out | output | 1 | Waveform output |
| ovf_flag | output | 1 | Sticky arrival-at-zero flag |
| cmp_flag | output | 1 | Sticky compare-match flag |

## Verification
On every cycle the bound properties check that the count moves only on ticks and then by exactly one step, and that the pin and the match flag stay still between ticks. They also check that the pin is frozen while disconnected and that both flags hold until cleared, with an arrival at zero always raising the overflow flag. Other behaviour depends on where the compare value sits and on the history of writes, so only the bench scenarios show it. This covers the placement of each edge within the triangle, the delayed load at top, the constant outputs at the two extreme compare values, the turnaround transition when the value leaves top, and a flag set colliding with its clear.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;

    typedef enum logic [1:0] {
        CM_OFF     = 2'b00,
        CM_OFF_ALT = 2'b01,
        CM_NONINV  = 2'b10,
        CM_INV     = 2'b11
    } cmp_mode_e;

    // Which level a pin event asks for, before polarity is applied
    typedef enum logic [1:0] {
        LVL_NONE = 2'b00,
        LVL_UP   = 2'b01,
        LVL_DOWN = 2'b10
    } lvl_evt_e;

    typedef struct packed {
        logic fire;      // counter stepped this cycle
        logic at_top;    // step arrived at the top value
        logic at_bottom; // step arrived at zero
        logic going_up;  // direction after the step
    } step_s;

    function automatic logic mode_live(input cmp_mode_e m);
        return (m == CM_NONINV) || (m == CM_INV);
    endfunction

    function automatic logic pin_level(input lvl_evt_e e, input cmp_mode_e m);
        return (e == LVL_DOWN) ^ (m == CM_INV);
    endfunction

endpackage

// File: rtl/pcpwm_counter.sv
module pcpwm_counter
    import pcpwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_nxt,
    output step_s        step
);
    localparam logic [W-1:0] TOP    = '1;
    localparam logic [W-1:0] TOP_M1 = TOP - W'(1);
    localparam logic [W-1:0] ONE    = W'(1);

    logic up_q, up_nxt;

    always_comb begin
        cnt_nxt = cnt_q;
        up_nxt  = up_q;
        step    = '0;
        if (tick) begin
            step.fire = 1'b1;
            if (up_q) begin
                if (cnt_q == TOP_M1) begin
                    cnt_nxt     = TOP;
                    up_nxt      = 1'b0;
                    step.at_top = 1'b1;
                end else begin
                    cnt_nxt = cnt_q + ONE;
                end
            end else begin
                if (cnt_q == ONE) begin
                    cnt_nxt        = '0;
                    up_nxt         = 1'b1;
                    step.at_bottom = 1'b1;
                end else begin
                    cnt_nxt = cnt_q - ONE;
                end
            end
            step.going_up = up_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else begin
            cnt_q <= cnt_nxt;
            up_q  <= up_nxt;
        end
    end

endmodule

// File: rtl/pcpwm_compare.sv
module pcpwm_compare
    import pcpwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fire,
    input  logic         at_top,
    input  logic         going_up,
    input  logic [W-1:0] cnt_nxt,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic         match,
    output lvl_evt_e     evt
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] hold_q, act_q, cmp_val;

    // At the turnaround the freshly loaded value is the one in force
    assign cmp_val = at_top ? hold_q : act_q;

    always_comb begin
        match = fire && (cnt_nxt == cmp_val);
        evt   = LVL_NONE;
        if (match) begin
            evt = going_up ? LVL_UP : LVL_DOWN;
        end else if (at_top && (act_q == TOP)) begin
            evt = LVL_UP; // leaving top: restore symmetry about zero
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            act_q  <= '0;
        end else begin
            if (wr)     hold_q <= wdata;
            if (at_top) act_q  <= hold_q;
        end
    end

endmodule

// File: rtl/pcpwm_output.sv
module pcpwm_output
    import pcpwm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cmp_mode_e mode,
    input  lvl_evt_e  evt,
    input  logic      match,
    input  logic      at_bottom,
    input  logic      ovf_clr,
    input  logic      cmp_clr,
    output logic      pin_q,
    output logic      ovf_q,
    output logic      cmp_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= 1'b0;
            ovf_q <= 1'b0;
            cmp_q <= 1'b0;
        end else begin
            if ((evt != LVL_NONE) && mode_live(mode)) begin
                pin_q <= pin_level(evt, mode);
            end
            ovf_q <= at_bottom | (ovf_q & ~ovf_clr);
            cmp_q <= match | (cmp_q & ~cmp_clr);
        end
    end

endmodule

// File: rtl/pcpwm_timer.sv
module pcpwm_timer
    import pcpwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         ocr_wr,
    input  logic [W-1:0] ocr_wdata,
    input  logic [1:0]   mode,
    input  logic         ovf_clr,
    input  logic         cmp_clr,
    output logic [W-1:0] cnt_o,
    output logic         pwm_out,
    output logic         ovf_flag,
    output logic         cmp_flag
);
    logic [W-1:0] cnt_nxt;
    step_s        step;
    logic         match;
    lvl_evt_e     evt;

    pcpwm_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .cnt_q   (cnt_o),
        .cnt_nxt (cnt_nxt),
        .step    (step)
    );

    pcpwm_compare #(.W(W)) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .fire     (step.fire),
        .at_top   (step.at_top),
        .going_up (step.going_up),
        .cnt_nxt  (cnt_nxt),
        .wr       (ocr_wr),
        .wdata    (ocr_wdata),
        .match    (match),
        .evt      (evt)
    );

    pcpwm_output u_out (
        .clk       (clk),
        .rst       (rst),
        .mode      (cmp_mode_e'(mode)),
        .evt       (evt),
        .match     (match),
        .at_bottom (step.at_bottom),
        .ovf_clr   (ovf_clr),
        .cmp_clr   (cmp_clr),
        .pin_q     (pwm_out),
        .ovf_q     (ovf_flag),
        .cmp_q     (cmp_flag)
    );

endmodule

// File: rtl/pcpwm_checker.sv
module pcpwm_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         tick,
    input logic [1:0]   mode,
    input logic         ovf_clr,
    input logic         cmp_clr,
    input logic [W-1:0] cnt_o,
    input logic         pwm_out,
    input logic         ovf_flag,
    input logic         cmp_flag
);
    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_o));

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt_o == W'($past(cnt_o) + 1'b1)) || (cnt_o == W'($past(cnt_o) - 1'b1)));

    p_ovf_set_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt_o == '0) && ($past(cnt_o) == W'(1)) |-> ovf_flag);

    p_ovf_hold_r3: assert property (@(posedge clk) disable iff (rst)
        ovf_flag && !ovf_clr |=> ovf_flag);

    p_cmp_hold_r4: assert property (@(posedge clk) disable iff (rst)
        cmp_flag && !cmp_clr |=> cmp_flag);

    p_cmp_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !tick && !cmp_flag |=> !cmp_flag);

    p_pin_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(pwm_out));

    p_pin_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        !mode[1] |=> $stable(pwm_out));

endmodule

bind pcpwm_timer pcpwm_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .mode     (mode),
    .ovf_clr  (ovf_clr),
    .cmp_clr  (cmp_clr),
    .cnt_o    (cnt_o),
    .pwm_out  (pwm_out),
    .ovf_flag (ovf_flag),
    .cmp_flag (cmp_flag)
);

// File: tb/tb_pcpwm_timer.sv
`timescale 1ns/1ps
module tb_pcpwm_timer;
    localparam int W   = 8;
    localparam int TOP = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick = 1'b0;
    logic         ocr_wr = 1'b0;
    logic [W-1:0] ocr_wdata = '0;
    logic [1:0]   mode = 2'b00;
    logic         ovf_clr = 1'b0;
    logic         cmp_clr = 1'b0;
    logic [W-1:0] cnt_o;
    logic         pwm_out, ovf_flag, cmp_flag;

    always #2.5 clk = ~clk;

    pcpwm_timer #(.W(W)) dut (
        .clk(clk), .rst(rst), .tick(tick), .ocr_wr(ocr_wr), .ocr_wdata(ocr_wdata),
        .mode(mode), .ovf_clr(ovf_clr), .cmp_clr(cmp_clr), .cnt_o(cnt_o),
        .pwm_out(pwm_out), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
    );

    typedef struct {
        int    cnt;
        bit    pin;
        bit    ovf;
        bit    cmp;
        string req;
    } exp_t;

    exp_t sb[$];
    event pushed;
    int   vectors = 0;
    int   fails   = 0;
    bit   done    = 0;

    // reference state, derived from the requirements
    int m_cnt = 0, m_buf = 0, m_act = 0;
    bit m_up = 1, m_pin = 0, m_ovf = 0, m_cmp = 0;

    task automatic push_now(string req);
        exp_t e;
        e.cnt = m_cnt; e.pin = m_pin; e.ovf = m_ovf; e.cmp = m_cmp; e.req = req;
        sb.push_back(e);
        -> pushed;
    endtask

    task automatic step_in(bit tk, bit wr, int wd, bit oc, bit cc, string req);
        bit top_hit = 0, bot_hit = 0, hit = 0;
        int lvl = 0; // 0 none, 1 up-match level, 2 down-match level
        @(negedge clk);
        tick = tk; ocr_wr = wr; ocr_wdata = W'(wd); ovf_clr = oc; cmp_clr = cc;
        if (tk) begin
            if (m_up) begin
                if (m_cnt + 1 == TOP) begin m_cnt = TOP; m_up = 0; top_hit = 1; end
                else m_cnt++;
            end else begin
                if (m_cnt - 1 == 0) begin m_cnt = 0; m_up = 1; bot_hit = 1; end
                else m_cnt--;
            end
            if (top_hit) begin
                if (m_buf == TOP) begin hit = 1; lvl = 2; end
                else if (m_act == TOP) lvl = 1;   // R10 leave-top transition
                m_act = m_buf;                    // R9 load at top
            end else if (m_cnt == m_act) begin
                hit = 1; lvl = m_up ? 1 : 2;
            end
        end
        if (lvl != 0 && mode[1]) m_pin = (lvl == 2) ^ mode[0];
        m_ovf = bot_hit | (m_ovf & !oc);
        m_cmp = hit | (m_cmp & !cc);
        if (wr) m_buf = wd;
        @(posedge clk);
        #1;
        push_now(req);
    endtask

    task automatic run(int n, string req);
        for (int i = 0; i < n; i++) step_in(1'b1, 1'b0, 0, 1'b0, 1'b0, req);
    endtask

    task automatic set_mode(logic [1:0] m);
        @(negedge clk);
        mode = m;
        tick = 1'b0; ocr_wr = 1'b0; ovf_clr = 1'b0; cmp_clr = 1'b0;
    endtask

    // monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            @(pushed);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                vectors++;
                if (int'(cnt_o) != e.cnt || pwm_out != e.pin ||
                    ovf_flag != e.ovf || cmp_flag != e.cmp) begin
                    fails++;
                    $display("FAIL %s: got cnt=%0d pin=%0b ovf=%0b cmp=%0b, expected cnt=%0d pin=%0b ovf=%0b cmp=%0b",
                             e.req, cnt_o, pwm_out, ovf_flag, cmp_flag, e.cnt, e.pin, e.ovf, e.cmp);
                end
            end
        end
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: got no finish, expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state with no tick
        step_in(1'b0, 1'b0, 0, 1'b0, 1'b0, "R1");

        // R9: value 100 written, active stays 0 until the first top
        mode = 2'b10;
        step_in(1'b1, 1'b1, 100, 1'b0, 1'b0, "R9");
        run(299, "R9");
        // R5: non-inverting edges at 100 on both slopes
        run(800, "R5");

        // R2: prescaled ticks, one in four cycles
        for (int i = 0; i < 1200; i++)
            step_in((i % 4) == 0, 1'b0, 0, 1'b0, 1'b0, "R2");

        // R3: overflow clear held, arrivals at zero still win
        for (int i = 0; i < 600; i++)
            step_in(1'b1, 1'b0, 0, 1'b1, 1'b0, "R3");
        run(20, "R3");
        // R4: match clear held, matches still win
        for (int i = 0; i < 600; i++)
            step_in(1'b1, 1'b0, 0, 1'b0, 1'b1, "R4");
        run(20, "R4");

        // R8: extreme compare values
        step_in(1'b1, 1'b1, 0, 1'b0, 1'b0, "R8");
        run(1100, "R8");
        step_in(1'b1, 1'b1, TOP, 1'b0, 1'b0, "R8");
        run(1100, "R8");
        set_mode(2'b11);
        run(1100, "R8");

        // R10: leave top with non-inverting output
        set_mode(2'b10);
        run(300, "R10");
        step_in(1'b1, 1'b1, 60, 1'b0, 1'b0, "R10");
        run(700, "R10");

        // R6: inverting polarity at value 60
        set_mode(2'b11);
        run(600, "R6");
        // R6 with R10: leave top while inverting
        step_in(1'b1, 1'b1, TOP, 1'b0, 1'b0, "R6");
        run(600, "R6");
        step_in(1'b1, 1'b1, 30, 1'b0, 1'b0, "R6");
        run(600, "R6");

        // R7: disconnected modes freeze the pin
        set_mode(2'b00);
        run(600, "R7");
        set_mode(2'b01);
        step_in(1'b1, 1'b1, 200, 1'b0, 1'b0, "R7");
        run(600, "R7");

        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule